// File: doc/BRIEF.md
# DMA Transfer Byte Counter with Start-Count Reload

This block keeps the byte count of a DMA transfer for a bus controller of the SCSI kind. Software programs a start count through byte-wide registers on a small byte-addressed register bus. Those writes only fill a shadow copy. The working counter, which software reads back and which a DMA engine decrements, takes the shadow value when a command byte with its DMA flag is written.

The block also keeps the terminal-count status bit. A byte write to the count clears that bit, and a completion pulse from the transfer logic sets it. Until software first writes the top count byte, a read of that byte returns a fixed identification constant. A transfer-start command that finds a zero count treats it as a full 65536-byte transfer.

Top module: `dma_tcount`

## Requirements
- R1: Synchronous reset clears the shadow count, the working count, the terminal-count bit, DMA mode, the read data register and the written-once mark of the top count byte.
- R2: Writes to addresses 0, 1 and 2 (count bits 7:0, 15:8, 23:16) change only the shadow count. Reads of those addresses return the working count, one cycle after the read request.
- R3: A write to address 3 is a command byte: bit 7 is the DMA flag and bits 6:0 are the opcode. With the flag set, the working count takes the shadow count and DMA mode is set. With the flag clear, the working count is kept and DMA mode is cleared.
- R4: A command with opcode 0x10 (transfer start) that finds a zero count loads 0x010000 (65536) into the working count. The count it checks is the reloaded count when the flag is set and the kept count when the flag is clear.
- R5: A write to any of addresses 0 to 2 clears the terminal-count bit. The status register at address 4 holds that bit in bit 4 and DMA mode in bit 7.
- R6: Reads of address 2 return the constant CHIP_ID (default 0xA2) until address 2 has been written once after reset. From then on they return working count bits 23:16.
- R7: A completion pulse forces the working count to zero and sets the terminal-count bit.
- R8: A decrement request lowers the working count by 1, or by 2 when the wide flag is set.
- R9: A decrement request at a working count of zero has no effect. A wide decrement at a count of one leaves zero, so the count never wraps.
- R10: In one cycle, a command write takes priority over completion, and completion takes priority over a decrement, for the working count. Completion setting the terminal-count bit takes priority over a count-byte write clearing it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| xfer_done | input | 1 | Transfer completion pulse |
| dec_req | input | 1 | Decrement request from the DMA engine |
| dec_wide | input | 1 | Decrement by two instead of one |
| work_count | output | CNT_W | Working count |
| dma_mode | output | 1 | DMA mode from the last command byte |
| tc_flag | output | 1 | Terminal-count status bit |

## Verification
Three updates can land on the working count in the same cycle: a command reload, completion and a decrement. Separately, completion setting the terminal-count bit can meet a count-byte write that clears it. The bench drives these pairs together on one clock edge in directed steps, and again at random. The working count and the status bit are compared every cycle against a behavioural model that applies the stated priority order.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
  localparam int TC_BIT  = 4;
  localparam int DMA_BIT = 7;
  localparam logic [6:0] OP_XFER = 7'h10;

  typedef struct packed {
    logic       dma;
    logic [6:0] op;
  } cmd_t;
endpackage

// File: rtl/tcnt_shadow.sv
module tcnt_shadow #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [CNT_W-1:0]  shadow,
  output logic              hi_written,
  output logic              cnt_wr
);
  localparam int NB = CNT_W / 8;
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(NB - 1);
  localparam logic [ADDR_W-1:0] A_END = ADDR_W'(NB);

  assign cnt_wr = wr_en && (addr < A_END);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        shadow[b*8 +: 8] <= '0;
      else if (wr_en && addr == ADDR_W'(b))
        shadow[b*8 +: 8] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      hi_written <= 1'b0;
    else if (wr_en && addr == A_HI)
      hi_written <= 1'b1;
  end

  // R6
  hi_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_HI) |=> hi_written);

  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr < A_END) |=> shadow == $past(shadow));
endmodule

// File: rtl/tcnt_work.sv
module tcnt_work
  import tcnt_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int FULL_LEN = 65536
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  cmd_t             cmd,
  input  logic [CNT_W-1:0] shadow,
  input  logic             done,
  input  logic             dec_req,
  input  logic             dec_wide,
  output logic [CNT_W-1:0] work_q,
  output logic             dma_q
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FULL_LEN);

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] step;

  always_comb begin
    base = cmd.dma ? shadow : work_q;
    step = dec_wide ? CNT_W'(2) : CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      dma_q  <= 1'b0;
    end else if (cmd_wr) begin
      dma_q <= cmd.dma;
      if (cmd.op == OP_XFER && base == '0)
        work_q <= FULL;
      else
        work_q <= base;
    end else if (done) begin
      work_q <= '0;
    end else if (dec_req && work_q != '0) begin
      work_q <= (work_q > step) ? work_q - step : '0;
    end
  end

  // R7
  done_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !cmd_wr) |=> work_q == '0);

  // R9
  dec_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (work_q == '0 && dec_req && !cmd_wr && !done) |=> work_q == '0);

  // R10
  cmd_over_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd.dma && cmd.op != OP_XFER) |=> work_q == $past(shadow));

  // R3
  no_dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !cmd.dma && cmd.op != OP_XFER) |=> (!dma_q && $stable(work_q)));

  // R8
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_req && !cmd_wr && !done && work_q > CNT_W'(2))
      |=> work_q == $past(work_q) - ($past(dec_wide) ? CNT_W'(2) : CNT_W'(1)));
endmodule

// File: rtl/dma_tcount.sv
module dma_tcount
  import tcnt_pkg::*;
#(
  parameter int          CNT_W    = 24,
  parameter int          ADDR_W   = 4,
  parameter logic [7:0]  CHIP_ID  = 8'hA2,
  parameter int          FULL_LEN = 65536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              xfer_done,
  input  logic              dec_req,
  input  logic              dec_wide,
  output logic [CNT_W-1:0]  work_count,
  output logic              dma_mode,
  output logic              tc_flag
);
  localparam int NB = CNT_W / 8;
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(NB - 1);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(NB);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NB + 1);

  logic [CNT_W-1:0] shadow;
  logic             hi_written;
  logic             cnt_wr;
  logic             cmd_wr;
  logic [7:0]       rd_mux;

  assign cmd_wr = reg_wr && reg_addr == A_CMD;

  tcnt_shadow #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .shadow     (shadow),
    .hi_written (hi_written),
    .cnt_wr     (cnt_wr)
  );

  tcnt_work #(.CNT_W(CNT_W), .FULL_LEN(FULL_LEN)) u_work (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .cmd      (cmd_t'(reg_wdata)),
    .shadow   (shadow),
    .done     (xfer_done),
    .dec_req  (dec_req),
    .dec_wide (dec_wide),
    .work_q   (work_count),
    .dma_q    (dma_mode)
  );

  always_ff @(posedge clk) begin
    if (rst)
      tc_flag <= 1'b0;
    else if (xfer_done)
      tc_flag <= 1'b1;
    else if (cnt_wr)
      tc_flag <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NB; b++)
      if (reg_addr == ADDR_W'(b))
        rd_mux = work_count[b*8 +: 8];
    if (reg_addr == A_HI && !hi_written)
      rd_mux = CHIP_ID;
    if (reg_addr == A_STAT) begin
      rd_mux[TC_BIT]  = tc_flag;
      rd_mux[DMA_BIT] = dma_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= rd_mux;
  end

  // R7
  tc_set_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> tc_flag);

  // R5
  tc_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr < A_CMD && !xfer_done) |=> !tc_flag);

  // R6
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_HI && !hi_written) |=> reg_rdata == CHIP_ID);
endmodule

// File: tb/test_dma_tcount.sv
module test_dma_tcount;
  localparam logic [7:0] ID = 8'hA2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0, xfer_done = 0, dec_req = 0, dec_wide = 0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [23:0] work_count;
  logic        dma_mode, tc_flag;

  always #2 clk = ~clk;

  dma_tcount i_dma_tcount (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .dec_req(dec_req), .dec_wide(dec_wide), .work_count(work_count),
    .dma_mode(dma_mode), .tc_flag(tc_flag)
  );

  int    n_chk = 0, n_err = 0;
  bit    ended = 0;
  string cur_req = "R1";

  int m_sh = 0, m_wk = 0, m_hiw = 0, m_tc = 0, m_dma = 0, m_rd = 0;

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic int m_read(int a);
    case (a)
      0: return m_wk & 255;
      1: return (m_wk >> 8) & 255;
      2: return m_hiw != 0 ? (m_wk >> 16) & 255 : int'(ID);
      4: return (m_tc << 4) | (m_dma << 7);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int a, d, base, st;
    a = int'(reg_addr);
    d = int'(reg_wdata);
    if (rst) begin
      m_sh = 0; m_wk = 0; m_hiw = 0; m_tc = 0; m_dma = 0; m_rd = 0;
    end else begin
      if (reg_rd) m_rd = m_read(a);
      if (reg_wr && a == 3) begin
        base  = (d >= 128) ? m_sh : m_wk;
        m_dma = (d >= 128) ? 1 : 0;
        m_wk  = ((d & 127) == 16 && base == 0) ? 65536 : base;
      end else if (xfer_done) begin
        m_wk = 0;
      end else if (dec_req && m_wk != 0) begin
        st   = dec_wide ? 2 : 1;
        m_wk = (m_wk > st) ? m_wk - st : 0;
      end
      if (xfer_done) m_tc = 1;
      else if (reg_wr && a < 3) m_tc = 0;
      if (reg_wr && a < 3) begin
        m_sh = (m_sh & ~(255 << (8 * a))) | (d << (8 * a));
        if (a == 2) m_hiw = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !ended) begin
      chk(cur_req, "work_count", int'(work_count), m_wk);
      chk(cur_req, "tc_flag", int'(tc_flag), m_tc);
      chk(cur_req, "dma_mode", int'(dma_mode), m_dma);
      chk(cur_req, "reg_rdata", int'(reg_rdata), m_rd);
    end
  end

  task automatic cyc(bit wr, int addr, int wd, bit rd, bit dn, bit dc, bit wide);
    reg_wr = wr; reg_addr = 4'(addr); reg_wdata = 8'(wd); reg_rd = rd;
    xfer_done = dn; dec_req = dc; dec_wide = wide;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; xfer_done = 0; dec_req = 0; dec_wide = 0;
  endtask

  task automatic wr(int addr, int wd);  cyc(1, addr, wd, 0, 0, 0, 0); endtask
  task automatic rd(int addr);          cyc(0, addr, 0, 1, 0, 0, 0); endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    cur_req = "R1";
    chk("R1", "work after reset", int'(work_count), 0);
    chk("R1", "tc after reset", int'(tc_flag), 0);
    rd(0);  chk("R1", "low byte read", int'(reg_rdata), 0);
    // R6 ID before write
    cur_req = "R6";
    rd(2);  chk("R6", "id read", int'(reg_rdata), int'(ID));
    // R2 shadow only
    cur_req = "R2";
    wr(0, 8'h34); wr(1, 8'h12);
    rd(0);  chk("R2", "low readback unchanged", int'(reg_rdata), 0);
    chk("R2", "work unchanged", int'(work_count), 0);
    cur_req = "R6";
    rd(2);  chk("R6", "id still present", int'(reg_rdata), int'(ID));
    wr(2, 8'h00);
    rd(2);  chk("R6", "high byte after write", int'(reg_rdata), 0);
    // R3 reload
    cur_req = "R3";
    wr(3, 8'h80);
    chk("R3", "reload", int'(work_count), 24'h001234);
    chk("R3", "dma set", int'(dma_mode), 1);
    wr(3, 8'h00);
    chk("R3", "hold on no flag", int'(work_count), 24'h001234);
    chk("R3", "dma cleared", int'(dma_mode), 0);
    // R8 decrement
    cur_req = "R8";
    cyc(0, 0, 0, 0, 0, 1, 0); chk("R8", "dec one", int'(work_count), 24'h001233);
    cyc(0, 0, 0, 0, 0, 1, 1); chk("R8", "dec two", int'(work_count), 24'h001231);
    // R7 completion
    cur_req = "R7";
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R7", "done zero", int'(work_count), 0);
    chk("R7", "done tc", int'(tc_flag), 1);
    rd(4); chk("R5", "status read", int'(reg_rdata), 8'h10);
    // R5 clear tc
    cur_req = "R5";
    wr(1, 8'h00); chk("R5", "tc cleared by count write", int'(tc_flag), 0);
    // R9 floor
    cur_req = "R9";
    cyc(0, 0, 0, 0, 0, 1, 0); chk("R9", "dec at zero", int'(work_count), 0);
    wr(0, 1); wr(3, 8'h80); chk("R9", "load one", int'(work_count), 1);
    cyc(0, 0, 0, 0, 0, 1, 1); chk("R9", "wide dec at one", int'(work_count), 0);
    // R4 zero means full length
    cur_req = "R4";
    wr(0, 0); wr(3, 8'h90);
    chk("R4", "zero -> 65536", int'(work_count), 65536);
    rd(2); chk("R4", "high byte of full length", int'(reg_rdata), 1);
    wr(3, 8'h10); chk("R4", "nonzero kept", int'(work_count), 65536);
    cyc(0, 0, 0, 0, 1, 0, 0);
    wr(3, 8'h10); chk("R4", "zero without flag", int'(work_count), 65536);
    // R10 collisions
    cur_req = "R10";
    wr(0, 8'h55);
    cyc(1, 3, 8'h80, 0, 0, 1, 0); chk("R10", "cmd beats dec", int'(work_count), 8'h55);
    cyc(1, 3, 8'h80, 0, 1, 0, 0); chk("R10", "cmd beats done", int'(work_count), 8'h55);
    chk("R10", "done tc with cmd", int'(tc_flag), 1);
    wr(0, 8'h01);
    cyc(0, 0, 0, 0, 1, 1, 0); chk("R10", "done beats dec", int'(work_count), 0);
    wr(0, 8'h02);
    cyc(1, 0, 8'h66, 0, 1, 0, 0); chk("R10", "done beats tc clear", int'(tc_flag), 1);
    // random mixed traffic, compared against the model each clock
    cur_req = "R10";
    for (int i = 0; i < 600; i++) begin
      int op, a, d;
      op = $urandom_range(0, 9);
      a  = $urandom_range(0, 5);
      d  = $urandom_range(0, 255);
      if (op == 9) d = (d & 8'h80) | 8'h10;
      cyc(op < 5, a, d, op >= 3 && op < 7, op == 8, op >= 5, d[0]);
    end
    finish_run();
  end
endmodule